// File: doc/BRIEF.md
# Multi-Channel Read Snapshot Latch

This block sits between eight converter channels and a host read port. Each channel gives a 16-bit word with an update strobe. The block keeps the last complete word of every channel in a holding register. A host read of a channel therefore always returns a whole word. It never returns a word that is only partly updated, and reads never stall the producers.

A write to the control register with the freeze bit set takes a snapshot of all eight channels at the same clock edge. From then on, a read of a frozen channel returns its snapshot. That read also releases the freeze for that channel alone. The other channels keep their snapshots until each is read in turn. A control write with the freeze bit clear releases every channel at once. While a channel is frozen, its holding register goes on tracking the strobes. After release, the next read returns the newest word.

Top module: `snap_latch_top`

## Requirements
- R1: After reset no channel is frozen, every holding register is 0 and `rd_vld` is 0. A read issued just after reset returns 0.
- R2: A channel's holding register loads `live_data[16*i +: 16]` only in a cycle where `live_stb[i]` is 1. A read of a channel that is not frozen returns the value held at the read edge. A strobe in the same cycle as the read is not yet visible to that read.
- R3: A control write with `ctl_wdata[1]` = 1 freezes all channels. A read of a frozen channel returns the snapshot, whatever strobes have arrived since the freeze.
- R4: A read of a frozen channel releases only that channel. The next read of the same channel returns its newest held word. Every other frozen channel keeps its snapshot.
- R5: A control write with `ctl_wdata[1]` = 0 releases every channel.
- R6: When a freeze write and a read fall in the same cycle, the read returns the value the channel showed before that edge, and the channel stays frozen.
- R7: Only bit 1 of `ctl_wdata` has an effect. All other bits are ignored. For example, 16'hFFFD acts as a release and 16'h0002 acts as a freeze.
- R8: `rd_vld` is 1 in the cycle after each cycle with `rd_en` = 1, and 0 otherwise. `rd_data` carries the read word whenever `rd_vld` is 1.
- R9: A strobe in the same cycle as a freeze write updates the holding register. The snapshot keeps the word held before that edge.
- R10: A freeze write while channels are already frozen recaptures every snapshot from the current holding registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| live_data | input | 128 | Eight live channel words; channel i in bits 16*i+15:16*i |
| live_stb | input | 8 | Per-channel update strobe; bit i marks a complete word on channel i |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 16 | Control write data; bit 1 = 1 freezes all, 0 releases all |
| rd_en | input | 1 | Host read request |
| rd_sel | input | 3 | Channel number to read |
| rd_data | output | 16 | Read word, registered, one cycle after the request |
| rd_vld | output | 1 | Marks rd_data as the answer to the previous request |

## Verification
The hardest situations to reach are a read that meets a control write or a strobe at the same edge. These include a freeze racing a read of a channel that is already frozen, and a freeze that coincides with a strobe on the very channel being captured. Directed sequences produce each of these collisions on purpose. A long run of seeded random cycles follows. In it, strobes, control writes and reads are drawn independently, so that such collisions recur across all channels and all freeze states. A bench model predicts each read from the state before the edge.

// File: rtl/snl_pkg.sv
package snl_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE   = 2'd0,
    CTL_FREEZE = 2'd1,
    CTL_THAW   = 2'd2
  } ctl_act_e;

  localparam int FRZ_BIT_DFLT = 1;

  // Action of one control-register access: only the freeze bit matters.
  function automatic ctl_act_e decode_act(input logic wr, input logic frz_bit);
    if (!wr)     return CTL_IDLE;
    if (frz_bit) return CTL_FREEZE;
    return CTL_THAW;
  endfunction

endpackage

// File: rtl/snl_ctl_decode.sv
module snl_ctl_decode
  import snl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic frz_bit,
  output logic freeze_evt,
  output logic thaw_evt
);

  ctl_act_e act;

  always_comb begin
    act        = decode_act(ctl_wr, frz_bit);
    freeze_evt = (act == CTL_FREEZE);
    thaw_evt   = (act == CTL_THAW);
  end

  // R7
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |-> (freeze_evt ^ thaw_evt));

  // R7
  idle_no_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |-> !(freeze_evt || thaw_evt));

endmodule

// File: rtl/snl_chan_hold.sv
module snl_chan_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          stb,
  input  logic          freeze_evt,
  input  logic          thaw_evt,
  input  logic          rd_hit,
  output logic [DW-1:0] view_word,
  output logic          frozen
);

  logic [DW-1:0] live_q;
  logic [DW-1:0] snap_q;
  logic          frz_q;

  // Freeze state after one edge: freeze outranks thaw and read release.
  function automatic logic next_frz(input logic cur, input logic frz,
                                    input logic thaw, input logic hit);
    if (frz)        return 1'b1;
    if (thaw || hit) return 1'b0;
    return cur;
  endfunction

  function automatic logic [DW-1:0] pick_view(input logic f,
                                              input logic [DW-1:0] s,
                                              input logic [DW-1:0] l);
    return f ? s : l;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      snap_q <= '0;
      frz_q  <= 1'b0;
    end else begin
      if (stb)        live_q <= din;
      if (freeze_evt) snap_q <= live_q;
      frz_q <= next_frz(frz_q, freeze_evt, thaw_evt, rd_hit);
    end
  end

  assign view_word = pick_view(frz_q, snap_q, live_q);
  assign frozen    = frz_q;

  // R2
  live_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (live_q == $past(din)));

  // R2
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(live_q));

  // R3
  snap_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && !freeze_evt) |=> $stable(snap_q));

  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && rd_hit && !freeze_evt) |=> !frz_q);

  // R5
  thaw_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thaw_evt |=> !frz_q);

  // R6
  freeze_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_evt |=> frz_q);

  // R9
  snap_pre_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_evt |=> (snap_q == $past(live_q)));

endmodule

// File: rtl/snl_read_mux.sv
module snl_read_mux #(
  parameter int NCH  = 8,
  parameter int DW   = 16,
  parameter int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [SELW-1:0]   rd_sel,
  input  logic [NCH*DW-1:0] view_bus,
  output logic [NCH-1:0]    rd_hit,
  output logic [DW-1:0]     rd_data,
  output logic              rd_vld
);

  logic [DW-1:0] picked;

  function automatic logic [NCH-1:0] sel_hit(input logic en,
                                             input logic [SELW-1:0] s);
    logic [NCH-1:0] h;
    h = '0;
    for (int i = 0; i < NCH; i++)
      if (en && (s == SELW'(i))) h[i] = 1'b1;
    return h;
  endfunction

  always_comb begin
    picked = '0;
    for (int i = 0; i < NCH; i++)
      if (rd_sel == SELW'(i)) picked = view_bus[i*DW +: DW];
  end

  assign rd_hit = sel_hit(rd_en, rd_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_data <= picked;
    end
  end

  // R8
  read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld);

  // R8
  no_spurious_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_vld);

  // R4
  hit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_hit));

endmodule

// File: rtl/snap_latch_top.sv
module snap_latch_top
  import snl_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int DW      = 16,
  parameter int FRZ_BIT = FRZ_BIT_DFLT,
  parameter int SELW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*DW-1:0] live_data,
  input  logic [NCH-1:0]    live_stb,
  input  logic              ctl_wr,
  input  logic [DW-1:0]     ctl_wdata,
  input  logic              rd_en,
  input  logic [SELW-1:0]   rd_sel,
  output logic [DW-1:0]     rd_data,
  output logic              rd_vld
);

  logic              freeze_evt;
  logic              thaw_evt;
  logic [NCH-1:0]    rd_hit;
  logic [NCH-1:0]    frozen_vec;
  logic [NCH*DW-1:0] view_bus;
  logic              unused_ctl_bits;

  assign unused_ctl_bits = ^ctl_wdata;

  snl_ctl_decode u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .frz_bit    (ctl_wdata[FRZ_BIT]),
    .freeze_evt (freeze_evt),
    .thaw_evt   (thaw_evt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    snl_chan_hold #(.DW(DW)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .din        (live_data[g*DW +: DW]),
      .stb        (live_stb[g]),
      .freeze_evt (freeze_evt),
      .thaw_evt   (thaw_evt),
      .rd_hit     (rd_hit[g]),
      .view_word  (view_bus[g*DW +: DW]),
      .frozen     (frozen_vec[g])
    );
  end

  snl_read_mux #(.NCH(NCH), .DW(DW), .SELW(SELW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .view_bus (view_bus),
    .rd_hit   (rd_hit),
    .rd_data  (rd_data),
    .rd_vld   (rd_vld)
  );

  // R3
  freeze_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_evt |=> (&frozen_vec));

  // R4
  single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && rd_en) |=> ($countones($past(frozen_vec) & ~frozen_vec) <= 1));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (frozen_vec == '0));

endmodule

// File: tb/snap_latch_top_tb.sv
`timescale 1ns/1ps
module snap_latch_top_tb;
  localparam int NCH = 8;
  localparam int DW  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH*DW-1:0] live_data = '0;
  logic [NCH-1:0]    live_stb = '0;
  logic              ctl_wr = 1'b0;
  logic [DW-1:0]     ctl_wdata = '0;
  logic              rd_en = 1'b0;
  logic [2:0]        rd_sel = '0;
  logic [DW-1:0]     rd_data;
  logic              rd_vld;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [DW-1:0] mlive [NCH];
  logic [DW-1:0] msnap [NCH];
  logic          mfrz  [NCH];
  logic          exp_vld;
  logic [DW-1:0] exp_data;

  always #2.5 clk = ~clk;

  snap_latch_top u_dut (
    .clk(clk), .rst_n(rst_n), .live_data(live_data), .live_stb(live_stb),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .rd_vld(rd_vld)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycles=%0d expected <= 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [DW-1:0] model_view(input int ch);
    return mfrz[ch] ? msnap[ch] : mlive[ch];
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    live_stb = '0; ctl_wr = 1'b0; ctl_wdata = '0; rd_en = 1'b0; rd_sel = '0;
  endtask

  // Called at a negedge with inputs set; advances one clock and checks.
  task automatic tick(input string tag);
    logic frz_w, thaw_w;
    exp_vld  = rd_en;
    exp_data = model_view(int'(rd_sel));
    frz_w  = ctl_wr && ctl_wdata[1];
    thaw_w = ctl_wr && !ctl_wdata[1];
    for (int c = 0; c < NCH; c++) begin
      if (frz_w) begin
        msnap[c] = mlive[c];
        mfrz[c]  = 1'b1;
      end else if (thaw_w || (rd_en && int'(rd_sel) == c)) begin
        mfrz[c] = 1'b0;
      end
      if (live_stb[c]) mlive[c] = live_data[c*DW +: DW];
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " vld"}, DW'(rd_vld), DW'(exp_vld));
    if (exp_vld) check(tag, rd_data, exp_data);
    idle_inputs();
  endtask

  task automatic put(input int ch, input logic [DW-1:0] v);
    live_data[ch*DW +: DW] = v;
    live_stb[ch] = 1'b1;
  endtask

  task automatic rd(input int ch);
    rd_en = 1'b1; rd_sel = 3'(ch);
  endtask

  task automatic wr(input logic [DW-1:0] w);
    ctl_wr = 1'b1; ctl_wdata = w;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < NCH; c++) begin
      mlive[c] = '0; msnap[c] = '0; mfrz[c] = 1'b0;
    end
    repeat (4) @(negedge clk);
    check("R1 vld in reset", DW'(rd_vld), '0);
    check("R1 data in reset", rd_data, '0);
    rst_n = 1'b1;

    // R1: read right after reset
    rd(3); tick("R1");
    for (int c = 0; c < NCH; c++) begin rd(c); tick("R1"); end

    // R2: strobed load, strobe during read not visible
    for (int c = 0; c < NCH; c++) put(c, DW'(16'h1100 + c));
    tick("R2");
    for (int c = 0; c < NCH; c++) begin rd(c); tick("R2"); end
    live_data[2*DW +: DW] = 16'hBEEF; tick("R2 no strobe");
    rd(2); tick("R2");
    put(5, 16'h5555); rd(5); tick("R2 same-cycle strobe");
    rd(5); tick("R2");

    // R3/R4: freeze, new strobes, reads release one at a time
    wr(16'h0002); tick("R3");
    for (int c = 0; c < NCH; c++) put(c, DW'(16'h2200 + c));
    tick("R3");
    rd(0); tick("R3 frozen");
    rd(0); tick("R4 released");
    rd(1); tick("R4 other frozen");
    put(1, 16'h2AAA); tick("R4");
    rd(1); tick("R4 newest after release");

    // R5: release all
    wr(16'h0000); tick("R5");
    for (int c = 0; c < NCH; c++) begin rd(c); tick("R5"); end

    // R7: other bits ignored
    wr(16'hFFFF); tick("R7 freeze");
    put(4, 16'h4444); tick("R7");
    rd(4); tick("R7 frozen by FFFF");
    wr(16'hFFFD); tick("R7 release");
    rd(6); tick("R7 released by FFFD");
    put(6, 16'h6666); tick("R7");
    rd(6); tick("R7");

    // R6: freeze and read in the same cycle
    wr(16'h0002); rd(3); tick("R6");
    put(3, 16'h3333); tick("R6");
    rd(3); tick("R6 still frozen");
    rd(3); tick("R6 released");
    wr(16'h0002); rd(7); tick("R6 already frozen");
    rd(7); tick("R6");
    wr(16'h0000); tick("R5");

    // R9: strobe together with freeze
    put(2, 16'h9999); wr(16'h0002); tick("R9");
    rd(2); tick("R9 snapshot pre-strobe");
    rd(2); tick("R9 newest");

    // R10: refreeze recaptures
    put(5, 16'hAAAA); tick("R10");
    wr(16'h0002); tick("R10");
    rd(5); tick("R10 refreshed");
    wr(16'h0000); tick("R5");

    // R8: isolated reads and gaps
    tick("R8 idle");
    rd(1); tick("R8");
    tick("R8 idle after");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      string tg;
      for (int c = 0; c < NCH; c++)
        if ($urandom_range(3) == 0) put(c, DW'($urandom));
      if ($urandom_range(9) == 0) wr(DW'($urandom));
      if ($urandom_range(1) == 0) rd(int'($urandom_range(NCH-1)));
      if (rd_en && ctl_wr && ctl_wdata[1]) tg = "R6 rand";
      else if (rd_en && mfrz[int'(rd_sel)]) tg = "R3 rand";
      else tg = "R2 rand";
      tick(tg);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule